// File: doc/BRIEF.md
# Valley-Switching Gate Timing Controller

This block sets the gate-drive request of the main power switch in a quasi-resonant flyback converter. All of its inputs are already digitized comparator outputs and control words. While the switch is off, the block counts the valleys of the demagnetisation ringing. These are the falling crossings of the zero-crossing sense below its first threshold. The block turns the switch back on in the valley whose number equals a skip count supplied by an outer regulation loop, but only while the sense signal is still below that threshold. An off-time limit forces a turn-on, so the converter never drops to a very low switching frequency. An active-burst input suppresses every turn-on.

The block ends each on-phase when the current comparator reports that the measured current has exceeded the regulation level. It ignores that comparator for a fixed blanking interval after every turn-on, so the switching spike cannot end the pulse early. After each turn-off, a suppression window masks the ringing directly after the edge. The window is long when the sense level is below a second threshold at turn-off, and short otherwise. All durations are counted in system clock cycles and set by parameters.

Top module: `qr_gate_timer`

## Requirements
- R1: While rstN is low, gateDrive is 0 and the valley counter, the off-time timer and the suppression window are all cleared.
- R2: While the gate is off and no suppression window is running, each 0-to-1 transition of zcBelowT1 (1 = sense below the first threshold) raises the valley counter by one. The transition counts at the clock edge that first samples zcBelowT1 as 1.
- R3: When the valley count equals skipCount (valid range 1 to 7), zcBelowT1 is 1 and no window is running, gateDrive rises at that clock edge. If zcBelowT1 is already 0 again when the count matches, no valley turn-on happens.
- R4: The valley counter clears at every turn-on and saturates at 7 instead of wrapping.
- R5: After MAX_OFF clock edges with the gate off, gateDrive rises at the next edge even without a valley match. The off-time timer holds at its limit until a turn-on happens.
- R6: While burstMode is 1, gateDrive does not rise, neither from a valley match nor from the off-time limit. Valley counting continues during burst. If a turn-on condition is already met when burstMode returns to 0, gateDrive rises at the first edge that samples burstMode as 0.
- R7: curOverReg is ignored for BLANK_CYC edges after a turn-on. Gate-on therefore lasts at least BLANK_CYC+1 cycles. After that, gateDrive falls at the first edge that samples curOverReg as 1, and turn-off wins over turn-on in the same cycle.
- R8: At turn-off, a suppression window of SUPP_LONG cycles starts if zcBelowT2 is 1 (1 = below the second threshold), or SUPP_SHORT cycles if it is 0. zcBelowT1 transitions during the window are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| zcBelowT1 | input | 1 | Zero-crossing sense below first threshold |
| zcBelowT2 | input | 1 | Zero-crossing sense below second threshold |
| curOverReg | input | 1 | Measured current above regulation level |
| skipCount | input | 3 | Valley number at which to turn on (1 to 7) |
| burstMode | input | 1 | Active burst: suppress all turn-ons |
| gateDrive | output | 1 | Gate-drive request of the switch |

## Verification
Several properties are checked on every cycle:
- burst blocks every turn-on;
- gate-on survives the first cycle after a rise;
- every rise had a valley or an expired timer behind it, and every fall had the current comparator behind it;
- the window length loaded at turn-off follows the second threshold, and the valley count is frozen while a window runs;
- the counter clears at turn-on and holds at saturation;
- an expired off timer forces a turn-on.

Other behaviours only show through the bench's scenarios, which predict the edge of every gate transition:
- that the count of valleys matches the skip count, including a valley that arrives inside the window;
- that a short above-threshold pulse fails the level condition;
- that a saturated count, not a wrapped one, turns on after burst ends;
- that a current glitch inside blanking is ignored.

// File: rtl/qr_timing_pkg.sv
package qr_timing_pkg;

  // control -> datapath strobes
  typedef struct packed {
    logic turnOn;
    logic turnOff;
    logic gateOn;
  } qrCmd_t;

  // datapath -> control status
  typedef struct packed {
    logic countMatch;
    logic offExpired;
    logic blankDone;
    logic suppActive;
  } qrStat_t;

endpackage

// File: rtl/qr_timing_dpath.sv
module qr_timing_dpath
  import qr_timing_pkg::*;
#(
  parameter int ZC_MAX     = 7,
  parameter int BLANK_CYC  = 41,
  parameter int SUPP_LONG  = 40,
  parameter int SUPP_SHORT = 16,
  parameter int MAX_OFF    = 2000
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               zcBelow1,
  input  logic                               zcBelow2,
  input  logic [$clog2(ZC_MAX+1)-1:0]        skipCount,
  input  qrCmd_t                             cmd,
  output qrStat_t                            stat
);

  localparam int ZC_W    = $clog2(ZC_MAX + 1);
  localparam int SUP_MAX = (SUPP_LONG > SUPP_SHORT) ? SUPP_LONG : SUPP_SHORT;
  localparam int SUP_W   = (SUP_MAX < 1) ? 1 : $clog2(SUP_MAX + 1);
  localparam int OFF_W   = (MAX_OFF < 2) ? 1 : $clog2(MAX_OFF);
  localparam int BLK_W   = (BLANK_CYC < 1) ? 1 : $clog2(BLANK_CYC + 1);

  localparam logic [ZC_W-1:0]  ZC_TOP   = ZC_W'(ZC_MAX);
  localparam logic [SUP_W-1:0] SUP_LONG = SUP_W'(SUPP_LONG);
  localparam logic [SUP_W-1:0] SUP_SHRT = SUP_W'(SUPP_SHORT);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(MAX_OFF - 1);

  logic              zcPrev;
  logic              zcPulse;
  logic [ZC_W-1:0]   zcCnt;
  logic [SUP_W-1:0]  supCnt;
  logic [OFF_W-1:0]  offCnt;
  logic              blankDone;
  logic              suppActive;

  assign suppActive = (supCnt != '0);

  // falling crossing of the first threshold, qualified by gate-off and window
  assign zcPulse = !cmd.gateOn && !suppActive && zcBelow1 && !zcPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) zcPrev <= 1'b0;
    else       zcPrev <= zcBelow1;
  end

  // valley counter: clears on turn-on, saturates at the top value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             zcCnt <= '0;
    else if (cmd.turnOn)                   zcCnt <= '0;
    else if (zcPulse && (zcCnt != ZC_TOP)) zcCnt <= zcCnt + 1'b1;
  end

  // ringing suppression window, length picked by the second threshold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           supCnt <= '0;
    else if (cmd.turnOff) supCnt <= zcBelow2 ? SUP_LONG : SUP_SHRT;
    else if (suppActive) supCnt <= supCnt - 1'b1;
  end

  // off-time timer, holds at its limit until the next turn-on
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         offCnt <= '0;
    else if (cmd.gateOn || cmd.turnOn) offCnt <= '0;
    else if (offCnt != OFF_LAST)       offCnt <= offCnt + 1'b1;
  end

  // leading-edge blanking of the current comparator
  generate
    if (BLANK_CYC > 0) begin : g_blank
      localparam logic [BLK_W-1:0] BLK_LOAD = BLK_W'(BLANK_CYC);
      logic [BLK_W-1:0] blkCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                           blkCnt <= '0;
        else if (cmd.turnOn)                 blkCnt <= BLK_LOAD;
        else if (cmd.gateOn && blkCnt != '0) blkCnt <= blkCnt - 1'b1;
      end
      assign blankDone = (blkCnt == '0);
    end else begin : g_noblank
      assign blankDone = 1'b1;
    end
  endgenerate

  always_comb begin
    stat.countMatch = (zcCnt == skipCount);
    stat.offExpired = (offCnt == OFF_LAST);
    stat.blankDone  = blankDone;
    stat.suppActive = suppActive;
  end

  // window length loaded at turn-off follows the second threshold (R8)
  p_supp_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmd.gateOn) |-> (supCnt == ($past(zcBelow2) ? SUP_LONG : SUP_SHRT)));

  // no valley is counted while a window runs (R8)
  p_supp_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.gateOn && suppActive && !cmd.turnOn) |=> $stable(zcCnt));

  // counter saturates rather than wrapping (R4)
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    (zcCnt == ZC_TOP && !cmd.turnOn) |=> (zcCnt == ZC_TOP));

  // counter is empty after each turn-on (R4)
  p_cnt_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.turnOn |=> (zcCnt == '0));

endmodule

// File: rtl/qr_timing_ctrl.sv
module qr_timing_ctrl
  import qr_timing_pkg::*;
#(
  parameter int BLANK_CYC = 41
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    zcBelow1,
  input  logic    curOver,
  input  logic    burstEn,
  input  qrStat_t stat,
  output qrCmd_t  cmd,
  output logic    gateOn
);

  logic gateQ;
  logic valleyHit;
  logic setReq;
  logic offReq;

  // equality compare is only honoured with the sense still low and no window
  assign valleyHit = stat.countMatch && zcBelow1 && !stat.suppActive;
  assign setReq    = !gateQ && !burstEn && (valleyHit || stat.offExpired);
  assign offReq    = gateQ && stat.blankDone && curOver;

  always_comb begin
    cmd.turnOff = offReq;
    cmd.turnOn  = setReq && !offReq;   // turn-off wins
    cmd.gateOn  = gateQ;
  end

  // on/off flip-flop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           gateQ <= 1'b0;
    else if (offReq)     gateQ <= 1'b0;
    else if (cmd.turnOn) gateQ <= 1'b1;
  end

  assign gateOn = gateQ;

  // burst holds the gate off (R6)
  p_burst_block_r6: assert property (@(posedge clk) disable iff (!rstN)
    (burstEn && !gateQ) |=> !gateQ);

  // an expired off timer forces a turn-on (R5)
  p_max_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!gateQ && !burstEn && stat.offExpired) |=> gateQ);

  // every rise has a valley in the low state or an expired timer behind it (R3)
  p_rise_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateQ) |-> ($past(zcBelow1) || $past(stat.offExpired)));

  // every fall has the current comparator behind it (R7)
  p_fall_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gateQ) |-> $past(curOver));

  generate
    if (BLANK_CYC > 0) begin : g_blank_chk
      // the blanking interval keeps the gate on past its first cycle (R7)
      p_blank_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
        $rose(gateQ) |=> gateQ);
    end
  endgenerate

endmodule

// File: rtl/qr_gate_timer.sv
module qr_gate_timer
  import qr_timing_pkg::*;
#(
  parameter int ZC_MAX     = 7,
  parameter int BLANK_CYC  = 41,
  parameter int SUPP_LONG  = 40,
  parameter int SUPP_SHORT = 16,
  parameter int MAX_OFF    = 2000
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        zcBelowT1,
  input  logic                        zcBelowT2,
  input  logic                        curOverReg,
  input  logic [$clog2(ZC_MAX+1)-1:0] skipCount,
  input  logic                        burstMode,
  output logic                        gateDrive
);

  qrCmd_t  cmd;
  qrStat_t stat;

  qr_timing_dpath #(
    .ZC_MAX(ZC_MAX), .BLANK_CYC(BLANK_CYC), .SUPP_LONG(SUPP_LONG),
    .SUPP_SHORT(SUPP_SHORT), .MAX_OFF(MAX_OFF)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .zcBelow1(zcBelowT1), .zcBelow2(zcBelowT2),
    .skipCount(skipCount), .cmd(cmd), .stat(stat)
  );

  qr_timing_ctrl #(.BLANK_CYC(BLANK_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .zcBelow1(zcBelowT1), .curOver(curOverReg),
    .burstEn(burstMode), .stat(stat), .cmd(cmd), .gateOn(gateDrive)
  );

endmodule

// File: tb/sim_qr_gate_timer.sv
`timescale 1ns/1ps
module sim_qr_gate_timer;

  localparam int BLANK  = 41;
  localparam int LONGW  = 40;
  localparam int SHORTW = 16;
  localparam int MAXOFF = 2000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic zcBelowT1 = 1'b0, zcBelowT2 = 1'b0, curOverReg = 1'b0, burstMode = 1'b0;
  logic [2:0] skipCount = 3'd1;
  logic gateDrive;

  always #4 clk = ~clk;   // 125 MHz

  qr_gate_timer #(.ZC_MAX(7), .BLANK_CYC(BLANK), .SUPP_LONG(LONGW),
                  .SUPP_SHORT(SHORTW), .MAX_OFF(MAXOFF)) u0 (
    .clk(clk), .rstN(rstN), .zcBelowT1(zcBelowT1), .zcBelowT2(zcBelowT2),
    .curOverReg(curOverReg), .skipCount(skipCount), .burstMode(burstMode),
    .gateDrive(gateDrive)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= rstN ? cyc + 1 : 0;

  typedef struct { int edgeNo; bit lvl; string req; } item_t;
  item_t expQ[$];
  int nChecks = 0, nFail = 0, lastFall = 0;
  bit finished = 0;
  logic prevGate = 1'b0;
  item_t it;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // monitor: every gate transition must match the head of the queue
  always @(negedge clk) begin
    if (rstN && gateDrive !== prevGate) begin
      if (expQ.size() == 0) begin
        check(0, "R3", "unexpected transition at edge", cyc, -1);
      end else begin
        it = expQ.pop_front();
        check(it.edgeNo == cyc && it.lvl == gateDrive, it.req,
              "transition edge", cyc, it.edgeNo);
      end
    end
    prevGate = gateDrive;
  end

  task automatic push(input int e, input bit l, input string r);
    item_t x;
    x.edgeNo = e; x.lvl = l; x.req = r;
    expQ.push_back(x);
  endtask

  task automatic waitTo(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drvPulse(input int c, input int hi);
    waitTo(c); zcBelowT1 = 1'b1;
    waitTo(c + hi); zcBelowT1 = 1'b0;
  endtask

  // expect a rise, then end the pulse with the current comparator
  task automatic onPhase(input int rise, input bit zc2, input string req);
    push(rise, 1'b1, req);
    waitTo(rise);
    zcBelowT1 = 1'b0; curOverReg = 1'b1; zcBelowT2 = zc2;
    push(rise + BLANK + 1, 1'b0, "R7");
    waitTo(rise + BLANK + 1);
    curOverReg = 1'b0;
    lastFall = rise + BLANK + 1;
  endtask

  initial begin
    int f;
    repeat (5) @(negedge clk);
    check(gateDrive == 1'b0, "R1", "gate during reset", gateDrive, 0);
    rstN = 1'b1;
    // R5: no valleys at all, the off-time limit forces the first turn-on
    onPhase(MAXOFF, 1'b1, "R5");
    // R2: long window; the pulse inside it and the one at +20 are ignored
    f = lastFall; skipCount = 3'd1;
    drvPulse(f + 1, 2); drvPulse(f + 20, 3);
    waitTo(f + 49); zcBelowT1 = 1'b1;
    onPhase(f + 51, 1'b0, "R2");
    // R8: short window; a valley at +20 is now counted
    f = lastFall;
    drvPulse(f + 1, 2);
    waitTo(f + 20); zcBelowT1 = 1'b1;
    onPhase(f + 22, 1'b1, "R8");
    // R3: third valley turns the gate on
    f = lastFall; skipCount = 3'd3;
    drvPulse(f + 50, 3); drvPulse(f + 60, 3);
    waitTo(f + 70); zcBelowT1 = 1'b1;
    onPhase(f + 72, 1'b1, "R3");
    // R4: count cleared at turn-on, one valley suffices again
    f = lastFall; skipCount = 3'd1;
    waitTo(f + 50); zcBelowT1 = 1'b1;
    onPhase(f + 52, 1'b1, "R4");
    // R3: the matching valley is left before the compare -> timer turn-on
    f = lastFall; skipCount = 3'd2;
    drvPulse(f + 50, 3); drvPulse(f + 60, 1);
    onPhase(f + MAXOFF, 1'b1, "R3");
    // R4/R6: nine valleys under burst saturate at 7; release turns on
    f = lastFall; skipCount = 3'd7; burstMode = 1'b1;
    for (int k = 0; k < 8; k++) drvPulse(f + 50 + 10 * k, 3);
    waitTo(f + 130); zcBelowT1 = 1'b1;
    waitTo(f + 140); burstMode = 1'b0;
    onPhase(f + 141, 1'b1, "R4");
    // R6: burst holds past the off-time limit
    f = lastFall; skipCount = 3'd1; burstMode = 1'b1;
    waitTo(f + MAXOFF + 20); burstMode = 1'b0;
    onPhase(f + MAXOFF + 21, 1'b1, "R6");
    // R7: comparator glitch inside blanking is ignored
    f = lastFall;
    waitTo(f + 50); zcBelowT1 = 1'b1;
    push(f + 52, 1'b1, "R3");
    waitTo(f + 52); zcBelowT1 = 1'b0; curOverReg = 1'b1;
    waitTo(f + 57); curOverReg = 1'b0;
    waitTo(f + 112); curOverReg = 1'b1;
    push(f + 113, 1'b0, "R7");
    waitTo(f + 113); curOverReg = 1'b0;
    waitTo(f + 213);
    check(expQ.size() == 0, "R7", "pending transitions", expQ.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL R1 watchdog expired: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule